// File: doc/BRIEF.md
# Programmable frame sync generator

This block produces a periodic frame-sync pulse for a serial port. The pulse width and the frame period are set by two fields and counted in bit-clock enable ticks, so the block runs on the system clock and advances only when the bit-clock tick is asserted. Two down-counters run side by side: one times how long the pulse stays high, the other times the whole frame. In the sync-to-external mode, the period count is ignored. Each frame is then started by a rising edge on the frame-sync pin, seen through a two-flop synchronizer.

A combinational routing stage picks the receive frame sync from one of three sources: the frame-sync pin, the generated pulse, or the transmit frame sync. The choice depends on the loopback, receive-mode and sync-to-external bits. The same stage applies the receive polarity and reports the pin direction. In loopback it also returns the serial data output to the receive data path.

The block carries no streaming data, so it has no valid/ready interface. All pins are plain control and status levels, sampled or updated every clock.

Top module: `fsync_pulse_gen`

## Requirements
- R1: `gen_fs` is 0 after reset. It is 0 one clock after any edge at which `gen_en` or `fs_mode` is 0, and it stays 0 while either is 0.
- R2: In free-running mode (`ext_sync_mode`=0), the first `bit_tick` after the generator becomes enabled starts a frame: `gen_fs` is 1 after that clock edge.
- R3: While the generator is enabled, `gen_fs` changes only at clock edges where `bit_tick` is 1.
- R4: A pulse stays high for `width_cfg`+1 ticks, from 1 to 256 ticks.
- R5: In free-running mode, a frame lasts `period_cfg`+1 ticks and the next pulse starts right after it. For example, a `period_cfg` of 15 gives a 16-tick frame.
- R6: When `width_cfg` is greater than or equal to `period_cfg`, `gen_fs` stays 1 continuously, and both counters reload together at each period expiry.
- R7: In sync-to-external mode (`ext_sync_mode`=1), `period_cfg` is ignored. A rising edge of `fs_pin_in` XOR `rx_polarity` passes through two synchronizer flops, and the next tick raises `gen_fs` for `width_cfg`+1 ticks. If that tick comes in every cycle, `gen_fs` rises at the third clock edge after the pin changes. Without a new edge, `gen_fs` stays 0.
- R8: `rx_fs` takes its source as follows:
  - the transmit frame sync `tx_fs` when `loopback`=1;
  - otherwise `gen_fs` when `rx_fs_mode`=1;
  - otherwise `fs_pin_in` XOR `rx_polarity`.
- R9: `fs_pin_dir` encodes 2'b00 as input, 2'b01 as output and 2'b10 as high impedance. Its value is set as follows:
  - output when `ext_sync_mode`=0, `rx_fs_mode`=1 and `loopback` is either value;
  - high impedance when `loopback`=1, `rx_fs_mode`=0 and `ext_sync_mode`=0;
  - input in every other case.
- R10: When `fs_pin_dir` is output, `fs_pin_out` equals the driven sync XOR `rx_polarity`. The driven sync is `tx_fs` in loopback and `gen_fs` otherwise. In every other direction `fs_pin_out` is 0.
- R11: `rx_data` equals `ser_dout` when `loopback`=1 and `ser_din` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | Bit-clock enable tick |
| gen_en | input | 1 | Generator enable |
| fs_mode | input | 1 | Frame-sync generation mode select |
| width_cfg | input | 8 | Pulse width minus one, in ticks |
| period_cfg | input | 12 | Frame period minus one, in ticks |
| ext_sync_mode | input | 1 | Start frames from the external pin edge |
| loopback | input | 1 | Digital loopback enable |
| rx_fs_mode | input | 1 | Receive frame sync from internal source |
| rx_polarity | input | 1 | Receive frame-sync inversion |
| tx_fs | input | 1 | Transmit frame sync (internal, active high) |
| fs_pin_in | input | 1 | Frame-sync pin input level |
| ser_dout | input | 1 | Serial data output from transmitter |
| ser_din | input | 1 | Serial data pin input |
| gen_fs | output | 1 | Generated frame sync |
| rx_fs | output | 1 | Selected receive frame sync (active high) |
| fs_pin_out | output | 1 | Frame-sync pin output level |
| fs_pin_dir | output | 2 | Pin direction: 00 input, 01 output, 10 high impedance |
| rx_data | output | 1 | Receive data after loopback selection |

## Verification
The bench runs pulses of width 1 and of width 256, and a 16-tick frame. A design that counts the width or period field without the +1 gives pulses or frames one tick short. It also runs width values at or above the period, including both fields at 0. A design that lets the width counter end the pulse before the period reload would show a low gap in a pulse that should stay high. A run with sparse ticks catches a design that counts clocks instead of ticks. The sync-to-external run expects no pulse before the pin edge, a rise exactly three edges after the pin changes, and no second pulse at the ignored period. The full routing table is checked against each source with both polarities, to expose a swapped table row or a missing inversion.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    PIN_IN  = 2'b00,
    PIN_OUT = 2'b01,
    PIN_HIZ = 2'b10
  } pin_dir_e;
endpackage

// File: rtl/fsg_edge_sync.sv
module fsg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], d};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fsg_pulse_core.sv
module fsg_pulse_core #(
  parameter int WB = 8,
  parameter int PB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic          sync_mode,
  input  logic          rise,
  input  logic [WB-1:0] width_cfg,
  input  logic [PB-1:0] period_cfg,
  output logic          fs_o
);
  logic [WB-1:0] wcnt;
  logic [PB-1:0] pcnt;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_o <= 1'b0;
      wcnt <= '0;
      pcnt <= '0;
      pend <= 1'b0;
    end else if (!active) begin
      fs_o <= 1'b0;
      wcnt <= '0;
      pcnt <= '0;
      pend <= 1'b0;
    end else if (sync_mode) begin
      if (tick && (pend || rise)) begin
        fs_o <= 1'b1;
        wcnt <= width_cfg;
        pcnt <= period_cfg;
        pend <= 1'b0;
      end else begin
        if (rise) pend <= 1'b1;
        if (tick && fs_o) begin
          if (wcnt == '0) fs_o <= 1'b0;
          else            wcnt <= wcnt - 1'b1;
        end
      end
    end else if (tick) begin
      if (pcnt == '0) begin
        fs_o <= 1'b1;
        wcnt <= width_cfg;
        pcnt <= period_cfg;
      end else begin
        pcnt <= pcnt - 1'b1;
        if (wcnt == '0) fs_o <= 1'b0;
        else            wcnt <= wcnt - 1'b1;
      end
    end
  end

  // R1
  fs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !fs_o);
  // R3
  fs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(fs_o));
  // R5
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sync_mode && tick && pcnt == '0) |=> fs_o);
  // R7
  no_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sync_mode && !fs_o && !rise && !pend) |=> !fs_o);
endmodule

// File: rtl/fsg_rx_route.sv
module fsg_rx_route
  import fsg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     loopback,
  input  logic     rx_mode,
  input  logic     ext_sync,
  input  logic     polarity,
  input  logic     tx_fs,
  input  logic     gen_fs,
  input  logic     pin_in,
  input  logic     ser_dout,
  input  logic     ser_din,
  output logic     rx_fs,
  output logic     pin_out,
  output pin_dir_e pin_dir,
  output logic     rx_data
);
  logic drive_src;

  always_comb begin
    if (loopback)     rx_fs = tx_fs;
    else if (rx_mode) rx_fs = gen_fs;
    else              rx_fs = pin_in ^ polarity;
  end

  always_comb begin
    if (ext_sync)      pin_dir = PIN_IN;
    else if (rx_mode)  pin_dir = PIN_OUT;
    else if (loopback) pin_dir = PIN_HIZ;
    else               pin_dir = PIN_IN;
  end

  assign drive_src = loopback ? tx_fs : gen_fs;
  assign pin_out   = (pin_dir == PIN_OUT) ? (drive_src ^ polarity) : 1'b0;
  assign rx_data   = loopback ? ser_dout : ser_din;

  // R10
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_dir != PIN_OUT) |-> (pin_out == 1'b0));
  // R9
  hiz_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_dir == PIN_HIZ) |-> (loopback && !ext_sync));
endmodule

// File: rtl/fsync_pulse_gen.sv
module fsync_pulse_gen
  import fsg_pkg::*;
#(
  parameter int WIDTH_BITS  = 8,
  parameter int PERIOD_BITS = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic                   gen_en,
  input  logic                   fs_mode,
  input  logic [WIDTH_BITS-1:0]  width_cfg,
  input  logic [PERIOD_BITS-1:0] period_cfg,
  input  logic                   ext_sync_mode,
  input  logic                   loopback,
  input  logic                   rx_fs_mode,
  input  logic                   rx_polarity,
  input  logic                   tx_fs,
  input  logic                   fs_pin_in,
  input  logic                   ser_dout,
  input  logic                   ser_din,
  output logic                   gen_fs,
  output logic                   rx_fs,
  output logic                   fs_pin_out,
  output logic [1:0]             fs_pin_dir,
  output logic                   rx_data
);
  logic     active;
  logic     pin_rise;
  pin_dir_e dir_w;

  assign active = gen_en & fs_mode;

  fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (fs_pin_in ^ rx_polarity),
    .rise (pin_rise)
  );

  fsg_pulse_core #(.WB(WIDTH_BITS), .PB(PERIOD_BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .tick      (bit_tick),
    .sync_mode (ext_sync_mode),
    .rise      (pin_rise),
    .width_cfg (width_cfg),
    .period_cfg(period_cfg),
    .fs_o      (gen_fs)
  );

  fsg_rx_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .loopback(loopback),
    .rx_mode (rx_fs_mode),
    .ext_sync(ext_sync_mode),
    .polarity(rx_polarity),
    .tx_fs   (tx_fs),
    .gen_fs  (gen_fs),
    .pin_in  (fs_pin_in),
    .ser_dout(ser_dout),
    .ser_din (ser_din),
    .rx_fs   (rx_fs),
    .pin_out (fs_pin_out),
    .pin_dir (dir_w),
    .rx_data (rx_data)
  );

  assign fs_pin_dir = dir_w;
endmodule

// File: tb/fsync_pulse_gen_test.sv
`timescale 1ns/1ps
module fsync_pulse_gen_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, gen_en = 0, fs_mode = 0, ext_sync_mode = 0;
  logic loopback = 0, rx_fs_mode = 0, rx_polarity = 0, tx_fs = 0;
  logic fs_pin_in = 0, ser_dout = 0, ser_din = 0;
  logic [7:0]  width_cfg = 0;
  logic [11:0] period_cfg = 0;
  logic gen_fs, rx_fs, fs_pin_out, rx_data;
  logic [1:0] fs_pin_dir;

  int checks = 0, errors = 0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  fsync_pulse_gen uut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares gen_fs after each edge against the scoreboard
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(gen_fs === e.v, e.tag, int'(gen_fs), int'(e.v));
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: free-running generator, tick every sp cycles
  task automatic run_gen(input int w, input int p, input int sp, input int n, input string tag);
    int k = -1;
    logic cur = 1'b0;
    @(negedge clk);
    width_cfg = w[7:0]; period_cfg = p[11:0];
    ext_sync_mode = 0; gen_en = 1; fs_mode = 1;
    for (int c = 0; c < n; c++) begin
      if (c > 0) @(negedge clk);
      bit_tick = ((c % sp) == 0);
      if (bit_tick) begin
        k++;
        cur = ((k % (p + 1)) <= w);
      end
      push(cur, (k == 0 && c == 0) ? "R2" : tag);
    end
    @(negedge clk);
    gen_en = 0; bit_tick = 0;
    push(1'b0, "R1");
    @(negedge clk);
    push(1'b0, "R1");
    drain();
  endtask

  function automatic logic [1:0] exp_dir(input logic lb, input logic m, input logic s);
    if (!lb) return !m ? 2'b00 : (s ? 2'b00 : 2'b01);
    return s ? 2'b00 : (m ? 2'b01 : 2'b10);
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gen_fs === 1'b0, "R1 reset gen_fs", int'(gen_fs), 0);
    rst_n = 1;
    @(negedge clk);
    chk(gen_fs === 1'b0, "R1 after reset", int'(gen_fs), 0);
    chk(fs_pin_dir === 2'b00, "R9 reset dir", int'(fs_pin_dir), 0);
    // R1: generator enabled but mode bit clear -> no pulse
    gen_en = 1; bit_tick = 1;
    repeat (6) begin
      @(negedge clk);
      chk(gen_fs === 1'b0, "R1 mode off", int'(gen_fs), 0);
    end
    gen_en = 0; bit_tick = 0;

    run_gen(0, 15, 1, 40, "R5 period 16");
    run_gen(3, 15, 1, 40, "R4 width 4");
    run_gen(255, 260, 1, 600, "R4 width 256");
    run_gen(3, 15, 3, 120, "R3 sparse ticks");
    run_gen(7, 3, 1, 30, "R6 width over period");
    run_gen(0, 0, 1, 10, "R6 both zero");

    // R7: sync-to-external mode
    @(negedge clk);
    fs_pin_in = 0; rx_polarity = 0; loopback = 0; rx_fs_mode = 0;
    repeat (4) @(negedge clk);
    width_cfg = 2; period_cfg = 3; ext_sync_mode = 1;
    gen_en = 1; fs_mode = 1; bit_tick = 1;
    push(1'b0, "R7 no edge");
    for (int i = 0; i < 7; i++) begin @(negedge clk); push(1'b0, "R7 no edge"); end
    @(negedge clk);
    fs_pin_in = 1;
    push(1'b0, "R7 sync stage 1");
    @(negedge clk); push(1'b0, "R7 sync stage 2");
    for (int i = 0; i < 3; i++) begin @(negedge clk); push(1'b1, "R7 pulse"); end
    for (int i = 0; i < 12; i++) begin @(negedge clk); push(1'b0, "R7 period ignored"); end
    @(negedge clk);
    gen_en = 0; bit_tick = 0; ext_sync_mode = 0; fs_pin_in = 0;
    push(1'b0, "R1");
    drain();

    // R8 R9 R10: routing table, gen_fs held at 0
    for (int lb = 0; lb < 2; lb++)
      for (int m = 0; m < 2; m++)
        for (int s = 0; s < 2; s++)
          for (int pl = 0; pl < 2; pl++)
            for (int pass = 0; pass < 2; pass++) begin
              logic e_rx, e_out;
              logic [1:0] e_dir;
              @(negedge clk);
              loopback = lb[0]; rx_fs_mode = m[0]; ext_sync_mode = s[0];
              rx_polarity = pl[0];
              tx_fs = (pass == 0);
              fs_pin_in = (pass == 0) ? pl[0] : ~pl[0];
              #1;
              e_rx  = lb[0] ? tx_fs : (m[0] ? 1'b0 : (fs_pin_in ^ pl[0]));
              e_dir = exp_dir(lb[0], m[0], s[0]);
              e_out = (e_dir == 2'b01) ? ((lb[0] ? tx_fs : 1'b0) ^ pl[0]) : 1'b0;
              chk(rx_fs === e_rx, "R8 source", int'(rx_fs), int'(e_rx));
              chk(fs_pin_dir === e_dir, "R9 direction", int'(fs_pin_dir), int'(e_dir));
              chk(fs_pin_out === e_out, "R10 pin drive", int'(fs_pin_out), int'(e_out));
            end

    // R10: generated pulse driven out inverted
    @(negedge clk);
    loopback = 0; rx_fs_mode = 1; ext_sync_mode = 0; rx_polarity = 1; fs_pin_in = 0;
    width_cfg = 0; period_cfg = 7; gen_en = 1; fs_mode = 1; bit_tick = 1;
    @(negedge clk);
    chk(gen_fs === 1'b1, "R2 start", int'(gen_fs), 1);
    chk(fs_pin_out === 1'b0, "R10 inverted gen", int'(fs_pin_out), 0);
    chk(rx_fs === 1'b1, "R8 gen source", int'(rx_fs), 1);
    gen_en = 0; bit_tick = 0;
    @(negedge clk);

    // R11: data loopback
    for (int lb = 0; lb < 2; lb++)
      for (int d = 0; d < 4; d++) begin
        @(negedge clk);
        loopback = lb[0]; ser_dout = d[0]; ser_din = d[1];
        #1;
        chk(rx_data === (lb[0] ? d[0] : d[1]), "R11 data path",
            int'(rx_data), int'(lb[0] ? d[0] : d[1]));
      end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule